// File: doc/BRIEF.md
# Received PAUSE Frame Detector with Transmit Hold-Off Timer

This block watches the byte stream of each received Ethernet frame and recognizes MAC control PAUSE requests from the link partner. When a valid request is recognized and receive flow control is enabled, the block loads a countdown of pause quanta. One quantum is 512 bit times. While quanta remain, the block holds off the local transmitter. The same parse also produces a forward or drop verdict for every frame, so the host path can discard control traffic according to two policy bits. Frame check sequence validation happens upstream, and its outcome arrives as an error flag on the last byte.

The receive stream uses a valid/ready handshake. The block never applies back-pressure: `rx_ready` is held high, and every cycle with `rx_valid` high consumes one byte. `rx_sof` marks the first byte of a frame. `rx_eof` marks the last byte, and `rx_err` is sampled together with it. `bit_tick` pulses once per line bit time. The timer only advances on cycles where `bit_tick` is high.

Top module: `pause_rx_ctl`

## Requirements
- R1: A frame counts as PAUSE only when all of these hold: it is at least 18 bytes long, bytes 0..5 equal 01 80 C2 00 00 01, bytes 12..13 equal 88 08, and bytes 14..15 equal 00 01.
- R2: Bytes 16..17 of a PAUSE frame form a big-endian quanta count N. Loading N keeps `tx_hold` high for exactly N*QUANTUM_BITS asserted `bit_tick` cycles.
- R3: With `cfg_rx_fc_en` low, a recognized PAUSE frame neither raises `tx_hold` nor changes either counter.
- R4: With `cfg_drop_pause` high, a recognized PAUSE frame gets `fr_pass`=0. With it low, the frame gets `fr_pass`=1.
- R5: A frame of 14 or more bytes whose type is 88 08 but which is not a PAUSE frame gets `fr_pass` equal to `cfg_pass_ctrl`.
- R6: A frame whose last byte carries `rx_err` gets `fr_pass`=0, leaves the timer unchanged and leaves both counters unchanged.
- R7: A new valid PAUSE frame reloads the timer with its own count, replacing the remainder. A count of zero drops `tx_hold` in the cycle the verdict appears.
- R8: The quanta remainder and `tx_hold` do not change on cycles where `bit_tick` is low.
- R9: Each acted-on PAUSE frame with count zero adds one to `xon_cnt`. Each acted-on PAUSE frame with a nonzero count adds one to `xoff_cnt`.
- R10: `rx_ready` is always 1. Two clock edges after the edge that accepts the last byte, `fr_done` is high for one cycle, and at that point the timer and counters already show the frame's effect. A frame with any other type gets `fr_pass`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Always 1; no back-pressure |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Frame error, qualified by rx_eof |
| bit_tick | input | 1 | One pulse per line bit time |
| cfg_rx_fc_en | input | 1 | Act on received PAUSE frames |
| cfg_drop_pause | input | 1 | Drop recognized PAUSE frames |
| cfg_pass_ctrl | input | 1 | Forward other control frames |
| tx_hold | output | 1 | Transmitter hold-off |
| fr_done | output | 1 | Verdict strobe, one per frame |
| fr_pass | output | 1 | Forward (1) or drop (0), valid with fr_done |
| xon_cnt | output | CNT_W | Zero-count PAUSE frames acted on |
| xoff_cnt | output | CNT_W | Nonzero-count PAUSE frames acted on |

## Verification
A wrong byte match or a wrong byte position in the parser shows up in the first `fr_pass` verdict, and in `tx_hold` failing to rise two edges after the last byte. A fault in the quantum divider or the reload path only appears when the hold-off ends, so each hold-off is measured to the exact cycle, up to thousands of cycles later. A hold-off that is wrongly gated by `bit_tick` or by the enable shows as `tx_hold` moving while ticks are stopped. A counter bug shows in the counter values read right after each verdict.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  localparam int IDX_W = 5;

  localparam logic [47:0]      PAUSE_DA   = 48'h0180C2000001;
  localparam logic [15:0]      CTRL_TYPE  = 16'h8808;
  localparam logic [15:0]      PAUSE_OP   = 16'h0001;

  localparam logic [IDX_W-1:0] POS_DA_END = 5'd6;
  localparam logic [IDX_W-1:0] POS_TYPE   = 5'd12;
  localparam logic [IDX_W-1:0] POS_OP     = 5'd14;
  localparam logic [IDX_W-1:0] POS_VAL    = 5'd16;
  localparam logic [IDX_W-1:0] LEN_CTRL   = 5'd14;
  localparam logic [IDX_W-1:0] LEN_PAUSE  = 5'd18;

  typedef struct packed {
    logic        done;
    logic        err;
    logic        pause;
    logic        ctrl;
    logic [15:0] val;
  } frame_sum_t;

  function automatic logic [7:0] da_byte(input logic [2:0] p);
    logic [47:0] sh;
    sh = PAUSE_DA << {p, 3'b000};
    return sh[47:40];
  endfunction

endpackage

// File: rtl/pfr_parser.sv
module pfr_parser
  import pfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_err,
  output frame_sum_t sum
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] pos;
  logic             da_bad_q, type_bad_q, op_bad_q;
  logic [15:0]      val_q;
  logic             end_q, err_q;

  assign pos = in_sof ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      da_bad_q   <= 1'b1;
      type_bad_q <= 1'b1;
      op_bad_q   <= 1'b1;
      val_q      <= '0;
      end_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      end_q <= in_valid & in_eof;
      err_q <= in_valid & in_eof & in_err;
      if (in_valid) begin
        if (pos < LEN_PAUSE) idx_q <= pos + 5'd1;
        if (pos == '0) begin
          da_bad_q   <= (in_data != da_byte(3'd0));
          type_bad_q <= 1'b0;
          op_bad_q   <= 1'b0;
        end else if (pos < POS_DA_END) begin
          da_bad_q <= da_bad_q | (in_data != da_byte(pos[2:0]));
        end
        if (pos == POS_TYPE)         type_bad_q <= (in_data != CTRL_TYPE[15:8]);
        if (pos == POS_TYPE + 5'd1)  type_bad_q <= type_bad_q | (in_data != CTRL_TYPE[7:0]);
        if (pos == POS_OP)           op_bad_q   <= (in_data != PAUSE_OP[15:8]);
        if (pos == POS_OP + 5'd1)    op_bad_q   <= op_bad_q | (in_data != PAUSE_OP[7:0]);
        if (pos == POS_VAL)          val_q[15:8] <= in_data;
        if (pos == POS_VAL + 5'd1)   val_q[7:0]  <= in_data;
      end
    end
  end

  always_comb begin
    sum.done  = end_q;
    sum.err   = err_q;
    sum.ctrl  = !type_bad_q && (idx_q >= LEN_CTRL);
    sum.pause = !da_bad_q && !type_bad_q && !op_bad_q && (idx_q >= LEN_PAUSE);
    sum.val   = val_q;
  end

endmodule

// File: rtl/pfr_policy.sv
module pfr_policy
  import pfr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_sum_t       sum,
  input  logic             cfg_fc_en,
  input  logic             cfg_drop_pause,
  input  logic             cfg_pass_ctrl,
  output logic             load,
  output logic [15:0]      load_val,
  output logic             fr_done,
  output logic             fr_pass,
  output logic [CNT_W-1:0] xon_cnt,
  output logic [CNT_W-1:0] xoff_cnt
);

  localparam int N_CNT = 2;

  logic             act;
  logic             pass_c;
  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  assign act      = sum.done & ~sum.err & sum.pause & cfg_fc_en;
  assign load     = act;
  assign load_val = sum.val;
  assign inc[0]   = act & (sum.val == 16'd0);
  assign inc[1]   = act & (sum.val != 16'd0);

  always_comb begin
    if (sum.err)        pass_c = 1'b0;
    else if (sum.pause) pass_c = ~cfg_drop_pause;
    else if (sum.ctrl)  pass_c = cfg_pass_ctrl;
    else                pass_c = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_done <= 1'b0;
      fr_pass <= 1'b0;
    end else begin
      fr_done <= sum.done;
      fr_pass <= sum.done & pass_c;
    end
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[i] <= '0;
      else if (inc[i]) cnt_q[i] <= cnt_q[i] + CNT_W'(1);
    end
  end

  assign xon_cnt  = cnt_q[0];
  assign xoff_cnt = cnt_q[1];

endmodule

// File: rtl/pfr_timer.sv
module pfr_timer #(
  parameter int QUANTUM_BITS = 512,
  parameter int VAL_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  input  logic             tick,
  output logic             hold,
  output logic [VAL_W-1:0] quanta
);

  localparam int BC_W = (QUANTUM_BITS > 2) ? $clog2(QUANTUM_BITS) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(QUANTUM_BITS - 1);

  logic [VAL_W-1:0] q_q;
  logic [BC_W-1:0]  bc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q  <= '0;
      bc_q <= '0;
    end else if (load) begin
      q_q  <= load_val;
      bc_q <= '0;
    end else if (q_q != '0 && tick) begin
      if (bc_q == BC_LAST) begin
        bc_q <= '0;
        q_q  <= q_q - VAL_W'(1);
      end else begin
        bc_q <= bc_q + BC_W'(1);
      end
    end
  end

  assign hold   = (q_q != '0);
  assign quanta = q_q;

endmodule

// File: rtl/pause_rx_ctl.sv
module pause_rx_ctl
  import pfr_pkg::*;
#(
  parameter int QUANTUM_BITS = 512,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_err,
  input  logic             bit_tick,
  input  logic             cfg_rx_fc_en,
  input  logic             cfg_drop_pause,
  input  logic             cfg_pass_ctrl,
  output logic             tx_hold,
  output logic             fr_done,
  output logic             fr_pass,
  output logic [CNT_W-1:0] xon_cnt,
  output logic [CNT_W-1:0] xoff_cnt
);

  localparam int VAL_W = 16;

  frame_sum_t       psum;
  logic             tmr_load;
  logic [VAL_W-1:0] tmr_val;
  logic [VAL_W-1:0] quanta_w;

  assign rx_ready = 1'b1;

  pfr_parser u_parse (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_sof(rx_sof),
    .in_eof(rx_eof), .in_err(rx_err), .sum(psum)
  );

  pfr_policy #(.CNT_W(CNT_W)) u_pol (
    .clk(clk), .rst_n(rst_n), .sum(psum),
    .cfg_fc_en(cfg_rx_fc_en), .cfg_drop_pause(cfg_drop_pause),
    .cfg_pass_ctrl(cfg_pass_ctrl),
    .load(tmr_load), .load_val(tmr_val),
    .fr_done(fr_done), .fr_pass(fr_pass),
    .xon_cnt(xon_cnt), .xoff_cnt(xoff_cnt)
  );

  pfr_timer #(.QUANTUM_BITS(QUANTUM_BITS), .VAL_W(VAL_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(bit_tick), .hold(tx_hold), .quanta(quanta_w)
  );

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_hold,
  input logic             fr_done,
  input logic             fr_pass,
  input logic [CNT_W-1:0] xoff_cnt,
  input logic             cfg_rx_fc_en,
  input logic             cfg_drop_pause,
  input logic             bit_tick,
  input logic             load,
  input logic [15:0]      load_val,
  input logic [15:0]      quanta,
  input logic             sum_done,
  input logic             sum_err,
  input logic             sum_pause
);

  AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> $past(cfg_rx_fc_en)); // R3

  AST_DROP_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && $past(sum_pause && cfg_drop_pause)) |-> !fr_pass); // R4

  AST_ERR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && $past(sum_err)) |-> !fr_pass); // R6

  AST_ERR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_done && sum_err) |=> (quanta <= $past(quanta))); // R6

  AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == 16'd0) |=> !tx_hold); // R7

  AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !load) |=> $stable(quanta)); // R8

  AST_XOFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_cnt != $past(xoff_cnt)) |-> (xoff_cnt == $past(xoff_cnt) + CNT_W'(1))); // R9

endmodule

bind pause_rx_ctl pfr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_hold(tx_hold), .fr_done(fr_done),
  .fr_pass(fr_pass), .xoff_cnt(xoff_cnt), .cfg_rx_fc_en(cfg_rx_fc_en),
  .cfg_drop_pause(cfg_drop_pause), .bit_tick(bit_tick), .load(tmr_load),
  .load_val(tmr_val), .quanta(quanta_w), .sum_done(psum.done),
  .sum_err(psum.err), .sum_pause(psum.pause)
);

// File: tb/sim_pause_rx_ctl.sv
`timescale 1ns/1ps
module sim_pause_rx_ctl;

  localparam int Q = 512;
  localparam int CW = 16;
  localparam logic [47:0] DA_OK = 48'h0180C2000001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready;
  logic          bit_tick = 1'b1;
  logic          cfg_rx_fc_en = 1'b1, cfg_drop_pause = 1'b0, cfg_pass_ctrl = 1'b0;
  logic          tx_hold, fr_done, fr_pass;
  logic [CW-1:0] xon_cnt, xoff_cnt;

  int   n_run = 0, n_fail = 0;
  bit   finished = 0;
  logic [7:0] fb[$];
  bit   exp_q[$];

  always #5 clk = ~clk;

  pause_rx_ctl #(.QUANTUM_BITS(Q), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .bit_tick(bit_tick), .cfg_rx_fc_en(cfg_rx_fc_en),
    .cfg_drop_pause(cfg_drop_pause), .cfg_pass_ctrl(cfg_pass_ctrl),
    .tx_hold(tx_hold), .fr_done(fr_done), .fr_pass(fr_pass),
    .xon_cnt(xon_cnt), .xoff_cnt(xoff_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] ty,
                       input logic [15:0] op, input logic [15:0] val, input int len);
    fb.delete();
    for (int i = 0; i < 6; i++) fb.push_back(da[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fb.push_back(8'h20 + 8'(i));
    fb.push_back(ty[15:8]); fb.push_back(ty[7:0]);
    fb.push_back(op[15:8]); fb.push_back(op[7:0]);
    fb.push_back(val[15:8]); fb.push_back(val[7:0]);
    while (fb.size() < len) fb.push_back(8'h00);
    while (fb.size() > len) void'(fb.pop_back());
  endtask

  task automatic send(input bit err, input bit exp_pass);
    exp_q.push_back(exp_pass);
    for (int i = 0; i < fb.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i];
      rx_sof = (i == 0); rx_eof = (i == fb.size() - 1);
      rx_err = err && (i == fb.size() - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic count_hold(output int n);
    n = 0;
    while (tx_hold && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: pops one expected verdict per fr_done strobe
  always @(negedge clk) begin
    if (rst_n && fr_done) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected verdict", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        chk(fr_pass == e, "R4/R5/R6/R10 verdict", fr_pass, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    finish_all();
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rx_ready == 1 && tx_hold == 0 && fr_done == 0, "R10 reset outputs", tx_hold, 0);
    chk(xon_cnt == 0 && xoff_cnt == 0, "R9 reset counters", xoff_cnt, 0);

    // R10 ordinary frame passes, verdict timing
    build(48'h001122334455, 16'h0800, 16'h4500, 16'h0000, 60);
    send(0, 1);
    @(negedge clk);
    chk(fr_done == 1, "R10 verdict two edges after last byte", fr_done, 1);
    chk(tx_hold == 0, "R10 ordinary frame no hold", tx_hold, 0);

    // R1 R2 valid pause, count 3
    build(DA_OK, 16'h8808, 16'h0001, 16'h0003, 60);
    send(0, 1);
    @(negedge clk);
    count_hold(n);
    chk(n == 3 * Q, "R2 hold length for count 3", n, 3 * Q);
    chk(xoff_cnt == 1, "R9 xoff after nonzero pause", xoff_cnt, 1);

    // R1 wrong destination: control frame, not pause
    build(48'h0180C2000002, 16'h8808, 16'h0001, 16'h0005, 60);
    send(0, 0);
    idle(3);
    chk(tx_hold == 0, "R1 wrong address no hold", tx_hold, 0);

    // R5 other control opcode forwarded when pass_ctrl set
    cfg_pass_ctrl = 1'b1;
    build(DA_OK, 16'h8808, 16'h0002, 16'h0005, 60);
    send(0, 1);
    idle(3);
    chk(tx_hold == 0, "R1 wrong opcode no hold", tx_hold, 0);

    // R4 drop pause, R9 xon
    cfg_drop_pause = 1'b1;
    build(DA_OK, 16'h8808, 16'h0001, 16'h0000, 60);
    send(0, 0);
    idle(2);
    chk(xon_cnt == 1, "R9 xon after zero pause", xon_cnt, 1);

    // R6 errored pause
    cfg_drop_pause = 1'b0;
    build(DA_OK, 16'h8808, 16'h0001, 16'h0005, 60);
    send(1, 0);
    idle(3);
    chk(tx_hold == 0, "R6 errored frame no hold", tx_hold, 0);
    chk(xoff_cnt == 1, "R6 errored frame no count", xoff_cnt, 1);

    // R3 flow control disabled
    cfg_rx_fc_en = 1'b0;
    build(DA_OK, 16'h8808, 16'h0001, 16'h0005, 60);
    send(0, 1);
    idle(3);
    chk(tx_hold == 0, "R3 disabled no hold", tx_hold, 0);
    chk(xoff_cnt == 1 && xon_cnt == 1, "R3 disabled no count", xoff_cnt, 1);

    // R7 reload replaces remainder
    cfg_rx_fc_en = 1'b1;
    build(DA_OK, 16'h8808, 16'h0001, 16'h000A, 60);
    send(0, 1);
    idle(100);
    build(DA_OK, 16'h8808, 16'h0001, 16'h0002, 60);
    send(0, 1);
    @(negedge clk);
    count_hold(n);
    chk(n == 2 * Q, "R7 reload hold length", n, 2 * Q);
    chk(xoff_cnt == 3, "R9 xoff after reloads", xoff_cnt, 3);

    // R7 zero releases at once
    build(DA_OK, 16'h8808, 16'h0001, 16'h000A, 60);
    send(0, 1);
    idle(20);
    chk(tx_hold == 1, "R7 hold before release", tx_hold, 1);
    build(DA_OK, 16'h8808, 16'h0001, 16'h0000, 60);
    send(0, 1);
    @(negedge clk);
    chk(tx_hold == 0, "R7 zero count releases", tx_hold, 0);
    chk(xon_cnt == 2 && xoff_cnt == 4, "R9 counts after release", xon_cnt, 2);

    // R8 no ticks, no progress
    bit_tick = 1'b0;
    build(DA_OK, 16'h8808, 16'h0001, 16'h0001, 60);
    send(0, 1);
    idle(2000);
    chk(tx_hold == 1, "R8 hold kept without ticks", tx_hold, 1);
    bit_tick = 1'b1;
    count_hold(n);
    chk(n == Q, "R8 full quantum after ticks resume", n, Q);

    // R1 short frame with pause signature is only a control frame
    build(DA_OK, 16'h8808, 16'h0001, 16'h0004, 16);
    send(0, 1);
    idle(3);
    chk(tx_hold == 0, "R1 short frame no hold", tx_hold, 0);

    idle(5);
    chk(exp_q.size() == 0, "R10 every frame got a verdict", exp_q.size(), 0);
    finish_all();
  end

endmodule